// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is the target side of a byte-addressed serial EEPROM on an SPI bus. A host selects it with an active-low chip select, shifts an 8-bit opcode into SI on rising SCK edges, follows with a 16-bit address sent most significant bit first, and then either shifts write data in or receives read data on SO. The SPI pins are brought into the system clock domain through a two-stage synchroniser, so SCK must be several system clocks slower than `clk`.

Written bytes are first gathered in a page buffer. They reach the array only after chip select rises on a byte boundary. A programming interval of `PROG_CYCLES` system clocks follows, and the ready/busy status bit stays set for that interval. A write enable latch gates every array or status write and clears itself when programming ends. A hold input freezes the serial logic and floats SO while the device stays selected. A write-protect input blocks status writes.

Top module: `eep_spi_target`

## Requirements
- R1: After reset the write enable latch, the busy flag and the status protect flag are 0, SO is not driven, and every array byte reads as 0x00.
- R2: Opcode values are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. The status byte carries busy in bit 0, the write enable latch in bit 1 and the protect flag in bit 7, with all other bits 0. It repeats for as long as the device stays selected.
- R3: Opcode 0x06 sets the write enable latch and 0x04 clears it.
- R4: A write command (or a status write) sent while the latch is clear changes neither the array nor the status.
- R5: A write of opcode, 16-bit address and one or more data bytes is committed only when chip select rises on a byte boundary. Busy then reads 1 for exactly `PROG_CYCLES` clocks, and the array holds the new bytes afterwards.
- R6: Within one write command the address wraps inside its 128-byte page, so a byte sent after page offset 127 lands at offset 0 of the same page.
- R7: A read returns array bytes MSB first on SO, with SI captured on rising SCK and SO changing after falling SCK (modes 0 and 3). The address increments across page boundaries while chip select stays low.
- R8: The write enable latch is 0 once a write or status-write programming interval ends.
- R9: If chip select rises while a byte is only partly received in a write, nothing is programmed, busy stays 0 and the latch is unchanged.
- R10: While busy, every opcode except read status is ignored: a read does not drive SO.
- R11: Hold is entered when HOLD falls while SCK is low and the device is selected. While held, SO is not driven and SCK edges are ignored. After release the transfer resumes where it paused.
- R12: A status write changes only the protect flag (data bit 7). It is ignored while WP is low.
- R13: An unknown opcode makes the device ignore all further bytes until chip select rises.
- R14: SO is never driven once chip select has been high for three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_wp_n | input | 1 | Write protect, active low |
| spi_so | output | 1 | Serial data out (valid when enabled) |
| spi_so_oe | output | 1 | Output enable for SO; low means high impedance |

## Verification
On every cycle the assertions check several properties: SO stays quiet when the device is deselected or held, busy only rises with the latch set, the array is written only inside the busy window, and that window lasts exactly `PROG_CYCLES` clocks and ends with the latch cleared. The bench's scenarios cover the rest by checking data at the pins. They show MSB-first ordering and address auto-increment on reads, and page wrap on writes. They also show the effect of an aborted write, commands ignored while busy, the unknown-opcode rule, status write masking and WP gating, and resumption after hold.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_ARR_RD    = 8'h03;
  localparam logic [7:0] OP_ARR_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_STAT_OUT,
    PH_STAT_IN,
    PH_DISCARD
  } phase_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= INIT;
      s2_q <= INIT;
      s3_q <= INIT;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign dout = s2_q;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE = 128,
  parameter int IW   = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid
);
  logic [7:0]      slot [PAGE];
  logic [PAGE-1:0] filled_q;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled_q <= '0;
    else if (we)    filled_q[widx] <= 1'b1;
  end

  assign rdata  = slot[ridx];
  assign rvalid = filled_q[ridx];
endmodule

// File: rtl/eep_spi_target.sv
module eep_spi_target
  import eep_pkg::*;
#(
  parameter int MEM_DEPTH   = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  input  logic spi_hold_n,
  input  logic spi_wp_n,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES);
  localparam int IX_CS = 4, IX_SCK = 3, IX_SI = 2, IX_HOLD = 1, IX_WP = 0;

  logic [4:0] pins_s, pins_rise, pins_fall;
  eep_sync #(.W(5), .INIT(5'b10011)) u_sync (
    .clk(clk), .rst(rst),
    .din({spi_cs_n, spi_sck, spi_si, spi_hold_n, spi_wp_n}),
    .dout(pins_s), .rise(pins_rise), .fall(pins_fall)
  );

  logic s_cs_n, s_si, s_wp_n, s_sck;
  assign s_cs_n = pins_s[IX_CS];
  assign s_sck  = pins_s[IX_SCK];
  assign s_si   = pins_s[IX_SI];
  assign s_wp_n = pins_s[IX_WP];

  logic        held_q, wel_q, busy_q, prot_q, prot_stage_q;
  logic        prog_arr_q, prog_stat_q, got_data_q, stat_full_q, addr_hi_done_q;
  logic [2:0]  bit_cnt_q;
  logic [6:0]  rx_sh_q, tx_sh_q;
  logic [7:0]  opcode_q;
  logic [15:0] addr_q;
  logic [15-PW:0] commit_page_q;
  logic [CW-1:0]  prog_cnt_q;
  phase_t      phase_q;

  logic sck_up, sck_dn, byte_end;
  logic [7:0] rx_byte, status_byte, arr_rdata, pb_rdata;
  logic pb_we, pb_clr, pb_valid, mem_we;
  logic [15:0] commit_addr;

  assign sck_up   = pins_rise[IX_SCK] && !s_cs_n && !held_q;
  assign sck_dn   = pins_fall[IX_SCK] && !s_cs_n && !held_q;
  assign byte_end = sck_up && (bit_cnt_q == 3'd7);
  assign rx_byte  = {rx_sh_q, s_si};
  assign status_byte = {prot_q, 5'b0, wel_q, busy_q};

  // hold: entered only on a HOLD falling edge with SCK low
  always_ff @(posedge clk) begin
    if (rst || s_cs_n)                                  held_q <= 1'b0;
    else if (!held_q && pins_fall[IX_HOLD] && !s_sck)   held_q <= 1'b1;
    else if (held_q && pins_s[IX_HOLD])                 held_q <= 1'b0;
  end

  assign pb_we  = byte_end && (phase_q == PH_WDATA);
  assign pb_clr = byte_end && (phase_q == PH_ADDR) && addr_hi_done_q && (opcode_q == OP_ARR_WR);

  eep_page_buf #(.PAGE(PAGE_BYTES), .IW(PW)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we),
    .widx(addr_q[PW-1:0]), .wdata(rx_byte),
    .ridx(prog_cnt_q[PW-1:0]), .rdata(pb_rdata), .rvalid(pb_valid)
  );

  assign commit_addr = {commit_page_q, prog_cnt_q[PW-1:0]};
  assign mem_we = prog_arr_q && (32'(prog_cnt_q) < PAGE_BYTES) && pb_valid;

  eep_array #(.DEPTH(MEM_DEPTH), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(commit_addr[AW-1:0]), .wdata(pb_rdata),
    .raddr(addr_q[AW-1:0]), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0; busy_q <= 1'b0; prot_q <= 1'b0; prot_stage_q <= 1'b0;
      prog_arr_q <= 1'b0; prog_stat_q <= 1'b0; prog_cnt_q <= '0;
      got_data_q <= 1'b0; stat_full_q <= 1'b0; addr_hi_done_q <= 1'b0;
      bit_cnt_q <= '0; rx_sh_q <= '0; opcode_q <= '0; addr_q <= '0;
      commit_page_q <= '0; phase_q <= PH_OPCODE;
    end else begin
      if (busy_q) begin
        if (prog_cnt_q == CW'(PROG_CYCLES - 1)) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
          if (prog_stat_q) prot_q <= prot_stage_q;
          prog_arr_q  <= 1'b0;
          prog_stat_q <= 1'b0;
        end else begin
          prog_cnt_q <= prog_cnt_q + 1'b1;
        end
      end

      if (pins_rise[IX_CS] && !busy_q && bit_cnt_q == 3'd0) begin
        if (phase_q == PH_WDATA && got_data_q) begin
          busy_q <= 1'b1; prog_arr_q <= 1'b1; prog_cnt_q <= '0;
          commit_page_q <= addr_q[15:PW];
        end else if (phase_q == PH_STAT_IN && stat_full_q) begin
          busy_q <= 1'b1; prog_stat_q <= 1'b1; prog_cnt_q <= '0;
        end
      end

      if (s_cs_n) begin
        bit_cnt_q <= '0;
        phase_q <= PH_OPCODE;
        addr_hi_done_q <= 1'b0;
      end else if (sck_up) begin
        rx_sh_q   <= rx_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (byte_end) begin
          case (phase_q)
            PH_OPCODE: begin
              opcode_q <= rx_byte;
              phase_q  <= PH_DISCARD;
              case (rx_byte)
                OP_LATCH_SET: if (!busy_q) wel_q <= 1'b1;
                OP_LATCH_CLR: if (!busy_q) wel_q <= 1'b0;
                OP_STAT_RD:   phase_q <= PH_STAT_OUT;
                OP_STAT_WR: begin
                  stat_full_q <= 1'b0;
                  if (!busy_q && wel_q && s_wp_n) phase_q <= PH_STAT_IN;
                end
                OP_ARR_RD:    if (!busy_q) phase_q <= PH_ADDR;
                OP_ARR_WR:    if (!busy_q && wel_q) phase_q <= PH_ADDR;
                default:      phase_q <= PH_DISCARD;
              endcase
            end
            PH_ADDR: begin
              if (!addr_hi_done_q) begin
                addr_q[15:8]   <= rx_byte;
                addr_hi_done_q <= 1'b1;
              end else begin
                addr_q[7:0] <= rx_byte;
                got_data_q  <= 1'b0;
                phase_q     <= (opcode_q == OP_ARR_RD) ? PH_RDATA : PH_WDATA;
              end
            end
            PH_WDATA: begin
              got_data_q <= 1'b1;
              addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
            end
            PH_RDATA:   addr_q <= addr_q + 16'd1;
            PH_STAT_IN: begin
              prot_stage_q <= rx_byte[7];
              stat_full_q  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // SO shifts on falling SCK; a fresh byte is loaded at each byte boundary
  always_ff @(posedge clk) begin
    if (rst || s_cs_n) begin
      spi_so <= 1'b0; spi_so_oe <= 1'b0; tx_sh_q <= '0;
    end else begin
      spi_so_oe <= !held_q && (phase_q == PH_RDATA || phase_q == PH_STAT_OUT);
      if (sck_dn && (phase_q == PH_RDATA || phase_q == PH_STAT_OUT)) begin
        if (bit_cnt_q == 3'd0) begin
          spi_so  <= (phase_q == PH_STAT_OUT) ? status_byte[7] : arr_rdata[7];
          tx_sh_q <= (phase_q == PH_STAT_OUT) ? status_byte[6:0] : arr_rdata[6:0];
        end else begin
          spi_so  <= tx_sh_q[6];
          tx_sh_q <= {tx_sh_q[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int PROG_CYCLES = 300
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_so_oe,
  input logic busy,
  input logic wel,
  input logic held,
  input logic mem_we
);
  logic [2:0] since_rst;
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= 0;
    else busy_len <= busy_len + 1;
  end

  assert_quiet_deselect_R14: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_so_oe);

  assert_busy_needs_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $rose(busy)) |-> wel);

  assert_latch_clear_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $fell(busy)) |-> !wel);

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $fell(busy)) |-> (busy_len == PROG_CYCLES));

  assert_array_write_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    held |=> !spi_so_oe);
endmodule

bind eep_spi_target eep_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
  .busy(busy_q), .wel(wel_q), .held(held_q), .mem_we(mem_we)
);

// File: tb/tb_eep_spi_target.sv
module tb_eep_spi_target;
  localparam int PROG = 300;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0;
  bit oe_seen = 1'b0;
  bit m_wel = 1'b0, m_prot = 1'b0;
  logic [7:0] ref_mem [int];

  always #5 clk = ~clk;

  eep_spi_target #(.MEM_DEPTH(1024), .PAGE_BYTES(128), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe)
  );

  always @(negedge clk) if (so_oe) oe_seen = 1'b1;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mem(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_sr(bit busy);
    return {m_prot, 5'b0, m_wel, busy};
  endfunction

  task automatic sel(); cs_n = 1'b0; tick(8); oe_seen = 1'b0; endtask
  task automatic desel(); tick(8); cs_n = 1'b1; tick(8); endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i]; tick(8); rx[i] = so;
      sck = 1'b1; tick(8); sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xbyte(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
  endtask

  task automatic wr(input int addr, input logic [7:0] q[$]);
    logic [7:0] d;
    sel(); xbyte(8'h02, d); xbyte(addr[15:8], d); xbyte(addr[7:0], d);
    foreach (q[i]) xbyte(q[i], d);
    desel();
  endtask

  task automatic model_wr(input int addr, input logic [7:0] q[$]);
    foreach (q[i]) ref_mem[(addr & 32'hFF80) | ((addr + i) & 32'h7F)] = q[i];
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xbyte(8'h01, d); xbyte(v, d); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic rd_chk(input int addr, input int n, input string req);
    logic [7:0] d;
    sel(); xbyte(8'h03, d); xbyte(addr[15:8], d); xbyte(addr[7:0], d);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, d);
      chk(req, d, exp_mem(addr + i));
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s, d, d2;
    tick(10); rst = 1'b0; tick(10);

    // R1: reset state
    chk("R1 so_oe after reset", so_oe, 0);
    rdsr(s); chk("R1 R2 status after reset", s, 8'h00);
    rd_chk(16'h0005, 1, "R1 array zero");

    // R4: write with latch clear ignored
    wr(16'h0010, '{8'hAA});
    rdsr(s); chk("R4 not busy after write without latch", s, exp_sr(0));
    rd_chk(16'h0010, 1, "R4 array unchanged");

    // R3: latch set and clear
    cmd(8'h06); m_wel = 1;
    rdsr(s); chk("R3 latch set", s, exp_sr(0));
    cmd(8'h04); m_wel = 0;
    rdsr(s); chk("R3 latch clear", s, exp_sr(0));

    // R5 R8 R7: write, busy window, read back
    cmd(8'h06); m_wel = 1;
    wr(16'h0020, '{8'h11, 8'h22, 8'hC3});
    rdsr(s); chk("R5 busy during programming", s, exp_sr(1));
    wait_idle(); model_wr(16'h0020, '{8'h11, 8'h22, 8'hC3}); m_wel = 0;
    rdsr(s); chk("R8 latch cleared after write", s, exp_sr(0));
    rd_chk(16'h001F, 5, "R7 R5 read back with increment");

    // R6: page wrap
    cmd(8'h06); m_wel = 1;
    wr(16'h017E, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
    wait_idle(); model_wr(16'h017E, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}); m_wel = 0;
    rd_chk(16'h0100, 3, "R6 wrapped bytes");
    rd_chk(16'h017E, 2, "R6 page tail");
    rd_chk(16'h0180, 1, "R6 next page untouched");
    rd_chk(16'h017F, 2, "R7 read crosses page");

    // R9: abort on partial byte
    cmd(8'h06); m_wel = 1;
    sel(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h30, d); xbyte(8'h55, d);
    for (int i = 0; i < 3; i++) begin si = 1'b1; tick(8); sck = 1'b1; tick(8); sck = 1'b0; end
    desel();
    rdsr(s); chk("R9 no programming, latch kept", s, exp_sr(0));
    rd_chk(16'h0030, 1, "R9 array unchanged");

    // R10: read ignored while busy
    wr(16'h0040, '{8'h77});
    sel(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h20, d); xbyte(8'h00, d);
    chk("R10 SO not driven while busy", oe_seen, 0);
    desel();
    wait_idle(); model_wr(16'h0040, '{8'h77}); m_wel = 0;
    rd_chk(16'h0040, 1, "R10 pending write completed");

    // R11: hold mid-read
    sel(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h20, d); xbyte(8'h00, d);
    chk("R11 byte before hold", d, 8'h11);
    hold_n = 1'b0; tick(8);
    chk("R11 SO released in hold", so_oe, 0);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; tick(6); sck = 1'b0; tick(6); end
    chk("R11 SO still released", so_oe, 0);
    hold_n = 1'b1; tick(8);
    xbyte(8'h00, d2);
    chk("R11 transfer resumes after hold", d2, 8'h22);
    desel();

    // R12: status write, masking and WP gate
    cmd(8'h06); m_wel = 1;
    wrsr(8'h80); wait_idle(); m_prot = 1; m_wel = 0;
    rdsr(s); chk("R12 protect flag set", s, exp_sr(0));
    cmd(8'h06); m_wel = 1;
    wp_n = 1'b0; tick(4);
    wrsr(8'h00);
    rdsr(s); chk("R12 status write blocked by WP", s, exp_sr(0));
    wp_n = 1'b1; tick(4);
    wrsr(8'h7F); wait_idle(); m_prot = 0; m_wel = 0;
    rdsr(s); chk("R12 only bit 7 written", s, exp_sr(0));

    // R13: unknown opcode swallows following bytes
    cmd(8'h06); m_wel = 1;
    sel(); xbyte(8'hAB, d); xbyte(8'h04, d); xbyte(8'h05, d);
    chk("R13 SO not driven after unknown opcode", oe_seen, 0);
    desel();
    rdsr(s); chk("R13 latch unaffected", s, exp_sr(0));
    cmd(8'h04); m_wel = 0;

    // R2: status repeats while selected
    sel(); xbyte(8'h05, d); xbyte(8'h00, d); xbyte(8'h00, d2); desel();
    chk("R2 status repeat", d2, exp_sr(0));

    // R14: deselected output quiet
    tick(20);
    chk("R14 SO off when deselected", so_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule